// File: doc/BRIEF.md
# Interleaved Subband Power Statistics Accumulator

This block sits behind a complex filterbank that serves two real signal paths, A and B. It receives one complex subband sample per accepted stream beat, with the two paths interleaved: A0, B0, A1, B1, up to the last subband of path B. For every sample it forms the power re² + im² at full precision. It then adds that power into an unsigned 64-bit accumulator kept for that path and subband. A sync marker on the first sample of an interval starts a new integration period. The usual interval is 16 filterbank blocks, but the length is set only by where the markers fall.

The accumulators live in two banks. Samples always accumulate into the live bank. The sample that carries the sync marker swaps the banks, which publishes the interval that just ended. Every bin written by the first block after the marker stores its power directly, so the published bank never needs a clearing pass. A 32-bit memory-mapped read port always returns data from the published bank. Each 64-bit statistic takes two word addresses. Bit 0 of the address selects the low or high half, bit 1 selects the path, and the upper bits give the subband. Reads take exactly one cycle.

The stream input is valid/ready. A beat transfers on a rising edge where both `s_valid` and `s_ready` are high. `s_ready` is low during reset and stays high from the first edge after reset, so the block never applies back-pressure. The source may insert idle cycles at will. `s_sync`, `s_re` and `s_im` are only looked at on transferring beats.

Top module: `subband_power_stats`

## Requirements
- R1: `s_ready` is 0 while `rst` is high and 1 on every cycle from the first clock edge after reset is released.
- R2: The power of a sample is re² + im² of the two signed DW-bit parts, computed without truncation. With DW = 18, an input of (-131072, -131072) gives 2^35.
- R3: Counting transferred beats from 0 at the sync beat, beat p goes to path p mod 2 (0 = A, 1 = B) and to subband p div 2. The count wraps to 0 after 2·NSUB beats.
- R4: Within one interval, each statistic equals the unsigned 64-bit sum of the powers of all beats that went to its bin.
- R5: The first block after a sync beat overwrites every bin it reaches. Nothing from earlier intervals carries over into those bins.
- R6: A read sampled on a clock edge later than the edge that transferred a sync beat returns the completed interval that ended at that beat. A read sampled on the same edge as the sync beat still returns the interval published before it.
- R7: In a read address, bit 0 selects the 32-bit half (0 = bits 31:0, 1 = bits 63:32), bit 1 selects the path (0 = A, 1 = B), and bits above bit 1 give the subband index.
- R8: `mm_rd_valid` is 1 exactly one cycle after a cycle with `mm_rd_en` = 1, and 0 otherwise. `mm_rd_data` carries the addressed word in that cycle.
- R9: A sync beat arriving in the middle of a block restarts the beat count at bin 0 (path A, subband 0).
- R10: Cycles without a transfer change no statistic and do not advance the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Stream sample present |
| s_ready | output | 1 | Block accepts the sample |
| s_sync | input | 1 | Beat is the first of a new interval |
| s_re | input | DW | Real part, signed |
| s_im | input | DW | Imaginary part, signed |
| mm_rd_en | input | 1 | Read request |
| mm_addr | input | log2(4·NSUB) | Word address |
| mm_rd_valid | output | 1 | Read data valid |
| mm_rd_data | output | 32 | Read data word |

## Verification
The bench builds the block with NSUB = 4 and the default DW = 18. That gives eight bins and sixteen word addresses, so one interval is only a few dozen cycles long. Bank swaps, overwrites by the first block, mid-block sync beats and reads on the swap edge then occur many times within a short run. Keeping DW at its full width means the extreme input -131072 exercises the largest power and carries into the high word of the statistic.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int STAT_W = 64;
  localparam int MM_W   = 32;
  localparam int WORDS  = STAT_W / MM_W;

  typedef logic [STAT_W-1:0] stat_t;
  typedef logic [MM_W-1:0]   mmword_t;

  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;

  function automatic mmword_t pick_word(input stat_t v, input half_e h);
    return (h == HALF_HI) ? v[STAT_W-1:MM_W] : v[MM_W-1:0];
  endfunction
endpackage

// File: rtl/sps_seq.sv
module sps_seq #(
  parameter int NBIN = 8,
  localparam int BINW = $clog2(NBIN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_valid,
  input  logic            s_sync,
  output logic            s_ready,
  output logic            acc,
  output logic [BINW-1:0] bin,
  output logic            fresh,
  output logic            wbank,
  output logic            rbank
);
  localparam logic [BINW-1:0] LAST = BINW'(NBIN - 1);

  logic [BINW-1:0] cnt_q;
  logic            first_q;
  logic            live_q;
  logic            rdy_q;

  assign s_ready = rdy_q;
  assign acc     = s_valid & rdy_q;
  assign bin     = s_sync ? '0 : cnt_q;
  assign fresh   = s_sync | first_q;
  assign wbank   = s_sync ? ~live_q : live_q;
  assign rbank   = ~live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      first_q <= 1'b0;
      live_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (acc) begin
        live_q  <= wbank;
        cnt_q   <= (bin == LAST) ? '0 : bin + 1'b1;
        first_q <= (bin == LAST) ? 1'b0 : fresh;
      end
    end
  end

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    s_ready |=> s_ready);

  // R6
  swap_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && s_sync) |=> (live_q != $past(live_q)));

  // R6
  hold_bank_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc && s_sync) |=> $stable(live_q));

  // R9
  restart_count_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && s_sync) |=> (cnt_q == BINW'(1)));

  // R10
  idle_count_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(cnt_q));
endmodule

// File: rtl/sps_power.sv
module sps_power #(
  parameter int DW   = 18,
  parameter int BINW = 3,
  localparam int PW  = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic [BINW-1:0]      in_bin,
  input  logic                 in_fresh,
  input  logic                 in_bank,
  output logic                 p_valid,
  output logic [PW-1:0]        p_pow,
  output logic [BINW-1:0]      p_bin,
  output logic                 p_fresh,
  output logic                 p_bank
);
  logic signed [DW-1:0] comp [2];
  logic [PW-1:0]        sq   [2];
  logic [PW-1:0]        sum;

  assign comp[0] = in_re;
  assign comp[1] = in_im;

  for (genvar g = 0; g < 2; g++) begin : g_sq
    logic signed [PW-1:0] prod;
    assign prod  = comp[g] * comp[g];
    assign sq[g] = $unsigned(prod);
  end

  assign sum = sq[0] + sq[1];

  always_ff @(posedge clk) begin
    if (rst) p_valid <= 1'b0;
    else     p_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      p_pow   <= sum;
      p_bin   <= in_bin;
      p_fresh <= in_fresh;
      p_bank  <= in_bank;
    end
  end

  // R2
  stage_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> p_valid);

  // R2
  power_bound_chk: assert property (@(posedge clk) disable iff (rst)
    p_valid |-> (p_pow <= (PW'(1) << (PW - 1))));
endmodule

// File: rtl/sps_store.sv
module sps_store
  import sps_pkg::*;
#(
  parameter int NBIN = 8,
  parameter int PW   = 36,
  localparam int BINW = $clog2(NBIN),
  localparam int DEPTH = 2 * NBIN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [BINW-1:0] wr_bin,
  input  logic            wr_bank,
  input  logic            wr_fresh,
  input  logic [PW-1:0]   wr_pow,
  input  logic            rd_en,
  input  logic            rd_bank,
  input  logic [BINW-1:0] rd_bin,
  input  logic            rd_half,
  output logic            rd_valid,
  output mmword_t         rd_data
);
  stat_t mem [DEPTH];
  stat_t old_v;
  stat_t add_v;
  stat_t new_v;

  assign old_v = mem[{wr_bank, wr_bin}];
  assign add_v = STAT_W'(wr_pow);
  assign new_v = wr_fresh ? add_v : old_v + add_v;

  always_ff @(posedge clk) begin
    if (wr_en) mem[{wr_bank, wr_bin}] <= new_v;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= pick_word(mem[{rd_bank, rd_bin}], half_e'(rd_half));
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  // R8
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  // R8
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_fresh) |-> (new_v >= old_v));

  // R6
  no_rd_live_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && (wr_bank == rd_bank)) |-> wr_fresh);
endmodule

// File: rtl/subband_power_stats.sv
module subband_power_stats
  import sps_pkg::*;
#(
  parameter int NSUB = 512,
  parameter int DW   = 18,
  localparam int NBIN = 2 * NSUB,
  localparam int BINW = $clog2(NBIN),
  localparam int AW   = BINW + 1,
  localparam int PW   = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic                 s_sync,
  input  logic signed [DW-1:0] s_re,
  input  logic signed [DW-1:0] s_im,
  input  logic                 mm_rd_en,
  input  logic [AW-1:0]        mm_addr,
  output logic                 mm_rd_valid,
  output logic [MM_W-1:0]      mm_rd_data
);
  logic            acc;
  logic [BINW-1:0] bin;
  logic            fresh;
  logic            wbank;
  logic            rbank;

  logic            p_valid;
  logic [PW-1:0]   p_pow;
  logic [BINW-1:0] p_bin;
  logic            p_fresh;
  logic            p_bank;

  sps_seq #(.NBIN(NBIN)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .s_valid (s_valid),
    .s_sync  (s_sync),
    .s_ready (s_ready),
    .acc     (acc),
    .bin     (bin),
    .fresh   (fresh),
    .wbank   (wbank),
    .rbank   (rbank)
  );

  sps_power #(.DW(DW), .BINW(BINW)) u_pow (
    .clk      (clk),
    .rst      (rst),
    .in_valid (acc),
    .in_re    (s_re),
    .in_im    (s_im),
    .in_bin   (bin),
    .in_fresh (fresh),
    .in_bank  (wbank),
    .p_valid  (p_valid),
    .p_pow    (p_pow),
    .p_bin    (p_bin),
    .p_fresh  (p_fresh),
    .p_bank   (p_bank)
  );

  sps_store #(.NBIN(NBIN), .PW(PW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (p_valid),
    .wr_bin   (p_bin),
    .wr_bank  (p_bank),
    .wr_fresh (p_fresh),
    .wr_pow   (p_pow),
    .rd_en    (mm_rd_en),
    .rd_bank  (rbank),
    .rd_bin   (mm_addr[AW-1:1]),
    .rd_half  (mm_addr[0]),
    .rd_valid (mm_rd_valid),
    .rd_data  (mm_rd_data)
  );

  // R1
  no_stall_chk: assert property (@(posedge clk) disable iff (rst)
    $past(s_ready) |-> s_ready);
endmodule

// File: tb/sim_subband_power_stats.sv
module sim_subband_power_stats;
  localparam int NSUB = 4;
  localparam int DW   = 18;
  localparam int NBIN = 2 * NSUB;
  localparam int AW   = $clog2(4 * NSUB);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0, s_sync = 1'b0, s_ready;
  logic signed [DW-1:0] s_re = '0, s_im = '0;
  logic mm_rd_en = 1'b0;
  logic [AW-1:0] mm_addr = '0;
  logic mm_rd_valid;
  logic [31:0] mm_rd_data;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  subband_power_stats #(.NSUB(NSUB), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_sync(s_sync),
    .s_re(s_re), .s_im(s_im), .mm_rd_en(mm_rd_en), .mm_addr(mm_addr),
    .mm_rd_valid(mm_rd_valid), .mm_rd_data(mm_rd_data)
  );

  // behavioural reference
  longint unsigned m_acc [NBIN];
  longint unsigned m_pub [NBIN];
  bit m_accd [NBIN];
  bit m_pubd [NBIN];
  int m_bin = 0;
  bit run = 0;
  bit e_v = 0, e_chk = 0;
  logic [31:0] e_d = '0;

  always @(posedge clk) begin
    run = !rst;
    if (rst) begin
      e_v = 0;
      for (int i = 0; i < NBIN; i++) begin m_pubd[i] = 0; m_accd[i] = 0; end
    end else begin
      e_v = mm_rd_en;
      if (mm_rd_en) begin
        int b;
        longint unsigned v;
        b = int'(mm_addr) / 2;
        v = m_pub[b];
        e_chk = m_pubd[b];
        e_d = mm_addr[0] ? v[63:32] : v[31:0];
      end
      if (s_valid && s_ready) begin
        longint r, q;
        if (s_sync) begin
          for (int i = 0; i < NBIN; i++) begin
            m_pub[i] = m_acc[i]; m_pubd[i] = m_accd[i];
            m_acc[i] = 0; m_accd[i] = 0;
          end
          m_bin = 0;
        end
        r = longint'(s_re); q = longint'(s_im);
        m_acc[m_bin] += longint'(r * r + q * q);
        m_accd[m_bin] = 1;
        m_bin = (m_bin + 1) % NBIN;
      end
    end
  end

  always @(negedge clk) begin
    if (run && !done) begin
      checks++;
      if (s_ready !== 1'b1) begin
        failures++;
        $display("FAIL R1 s_ready actual=%b expected=1", s_ready);
      end
      checks++;
      if (mm_rd_valid !== e_v) begin
        failures++;
        $display("FAIL R8 rd_valid actual=%b expected=%b", mm_rd_valid, e_v);
      end
      if (e_v && e_chk) begin
        checks++;
        if (mm_rd_data !== e_d) begin
          failures++;
          $display("FAIL R2 R3 R4 R5 R6 R7 R10 rd_data actual=%0d expected=%0d", mm_rd_data, e_d);
        end
      end
    end
  end

  task automatic cyc(bit v, bit sy, int re, int im, bit ren, int ad);
    s_valid = v; s_sync = sy; s_re = DW'(re); s_im = DW'(im);
    mm_rd_en = ren; mm_addr = AW'(ad);
    @(negedge clk);
  endtask

  task automatic send(bit sy, int re, int im);
    cyc(1, sy, re, im, 0, 0);
  endtask

  task automatic rd_chk(int ad, longint unsigned exp, string tag);
    cyc(0, 0, 0, 0, 1, ad);
    checks++;
    if (mm_rd_data !== exp[31:0]) begin
      failures++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, ad, mm_rd_data, exp[31:0]);
    end
  endtask

  function automatic int rv();
    return int'($urandom % 262144) - 131072;
  endfunction

  task automatic rand_interval(int nblk);
    for (int blk = 0; blk < nblk; blk++)
      for (int b = 0; b < NBIN; b++) begin
        if ($urandom % 5 == 0) cyc(0, 0, rv(), rv(), $urandom % 2 == 1, int'($urandom % 16));
        cyc(1, blk == 0 && b == 0, rv(), rv(), $urandom % 2 == 1, int'($urandom % 16));
      end
  endtask

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    checks++;  // R1 R8 reset state
    if (s_ready !== 1'b0 || mm_rd_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 R8 reset ready=%b rd_valid=%b expected=0 0", s_ready, mm_rd_valid);
    end
    rst = 1'b0;
    @(negedge clk);

    // first interval: random content
    rand_interval(3);

    // second interval: fixed pattern over two blocks with a gap (R10)
    for (int blk = 0; blk < 2; blk++)
      for (int b = 0; b < NBIN; b++) begin
        int re, im;
        re = 0; im = 0;
        if (b == 0) begin re = 1000; im = 1000; end
        if (b == 2) begin re = 3; im = 4; end
        if (b == 3) begin re = -131072; im = -131072; end
        if (blk == 1 && b == 4) cyc(0, 0, 77, 77, 0, 0);
        send(blk == 0 && b == 0, re, im);
      end

    // third interval: one block, bin 0 only
    send(1, 1, 0);
    rd_chk(0, 64'd4000000, "R4 R10");
    rd_chk(1, 64'd0, "R4");
    rd_chk(4, 64'd50, "R3");
    rd_chk(6, 64'd0, "R2 R7 low");
    rd_chk(7, 64'd16, "R2 R7 high");
    for (int b = 1; b < NBIN; b++) send(0, 0, 0);

    // fourth interval: read on the sync edge (R6), then a short block
    cyc(1, 1, 2, 0, 1, 0);
    checks++;
    if (mm_rd_data !== 32'd4000000) begin
      failures++;
      $display("FAIL R6 swap-edge read actual=%0d expected=4000000", mm_rd_data);
    end
    rd_chk(0, 64'd1, "R5 R6");
    send(0, 2, 0);
    send(0, 2, 0);

    // fifth interval starts mid-block (R9)
    send(1, 0, 2);
    rd_chk(2, 64'd4, "R9 R3");
    rd_chk(4, 64'd4, "R9");
    for (int b = 1; b < NBIN; b++) send(0, 0, b + 2);
    send(1, 0, 0);
    rd_chk(2, 64'd9, "R9");
    rd_chk(0, 64'd4, "R9 R5");
    rd_chk(14, 64'd81, "R7");
    for (int b = 1; b < NBIN; b++) send(0, 0, 0);

    // random intervals with gaps and reads
    for (int k = 0; k < 8; k++) rand_interval(1 + (k % 3));
    send(1, 0, 0);
    for (int a = 0; a < 4 * NSUB; a++) cyc(0, 0, 0, 0, 1, a);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule